// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the control part of a 32-bit processor that turns exception requests into mode changes. At an instruction boundary it picks the most urgent pending request, then in one clock cycle issues the register-file writes that enter the handler. Those writes save the return address into the target mode's link register and copy the current status word into that mode's saved-status register. They also write a new status word, with the new mode, the normal interrupt masked and the compact-instruction flag cleared, and load the program counter with the vector.

It also performs the exception return. On a return strobe it writes the saved status back into the current status register and loads the program counter from a supplied address, typically the link register minus 4. Restoring a saved status that had the compact-instruction flag set resumes 16-bit execution. Handler code and any register stacking stay outside the block.

Top module: `exc_sequencer`

## Requirements
- R1: In the first clock after reset is released, the block issues a reset entry: `pc_we` with `pc_wdata` = `VEC_BASE`, and `psr_we` with mode bits [4:0] = 5'b10011 (supervisor), bit 7 (normal-interrupt disable) = 1, bit 6 (fast-interrupt disable) = 1, bit 5 (compact-set flag) = 0 and bits [31:8] taken from `cur_psr`. `lr_we` and `spsr_we` stay low.
- R2: Requests are sampled only in a cycle where `boundary` is high. The resulting writes appear one clock later and last exactly one cycle.
- R3: Each source maps to a mode and a vector offset from `VEC_BASE`:
  - reset: 10011, 0x00
  - undefined instruction: 11011, 0x04
  - software interrupt: 10011, 0x08
  - prefetch abort: 10111, 0x0C
  - data abort: 10111, 0x10
  - normal interrupt: 10010, 0x18
  - fast interrupt: 10001, 0x1C
- R4: When several requests are taken together, the winner is chosen in this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R5: Every non-reset entry writes `pc_in`+4 to the link register and `cur_psr` to the saved-status register. Both writes go to the bank given by the target mode (`lr_bank`, `spsr_bank`).
- R6: The entry status word sets bit 7 and clears bit 5. It sets bit 6 only on fast-interrupt and reset entries, and otherwise keeps bit 6 and bits [31:8] from `cur_psr`.
- R7: A normal-interrupt request is ignored while `cur_psr` bit 7 is 1. A fast-interrupt request is ignored while bit 6 is 1.
- R8: A return strobe outside user mode writes `saved_psr` to the status register and `ret_pc` to the program counter, with no link or saved-status write. An exception taken in the same cycle wins over the return.
- R9: A return strobe while `cur_psr[4:0]` = 10000 (user) is ignored.
- R10: Offset 0x14 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary | input | 1 | Instruction boundary strobe |
| req_reset | input | 1 | Reset request |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabt | input | 1 | Prefetch-abort request |
| req_dabt | input | 1 | Data-abort request |
| req_irq | input | 1 | Normal-interrupt request (level) |
| req_fiq | input | 1 | Fast-interrupt request (level) |
| pc_in | input | AW | Current program counter |
| cur_psr | input | 32 | Current status word |
| saved_psr | input | 32 | Saved status of the current mode |
| ret_strobe | input | 1 | Exception-return strobe |
| ret_pc | input | AW | Return address |
| pc_we | output | 1 | Program-counter write enable |
| pc_wdata | output | AW | New program counter |
| psr_we | output | 1 | Status write enable |
| psr_wdata | output | 32 | New status word |
| lr_we | output | 1 | Link-register write enable |
| lr_bank | output | 5 | Mode bank of the link write |
| lr_wdata | output | AW | Return address to save |
| spsr_we | output | 1 | Saved-status write enable |
| spsr_bank | output | 5 | Mode bank of the saved-status write |
| spsr_wdata | output | 32 | Status word to save |

## Verification
The bench builds the block with `AW` = 32 and `VEC_BASE` = 32'hFFFF_0000. With that base, every vector check proves the offset is added to the base and not just emitted alone. It also brings the upper address bits into the link and vector arithmetic. The status words used set the compact-set flag and condition flags, so the bench can see that the flag is cleared and the flags are kept on entry.

// File: rtl/exc_sequencer.sv
module exc_sequencer #(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          req_reset,
  input  logic          req_undef,
  input  logic          req_swi,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          req_irq,
  input  logic          req_fiq,
  input  logic [AW-1:0] pc_in,
  input  logic [31:0]   cur_psr,
  input  logic [31:0]   saved_psr,
  input  logic          ret_strobe,
  input  logic [AW-1:0] ret_pc,
  output logic          pc_we,
  output logic [AW-1:0] pc_wdata,
  output logic          psr_we,
  output logic [31:0]   psr_wdata,
  output logic          lr_we,
  output logic [4:0]    lr_bank,
  output logic [AW-1:0] lr_wdata,
  output logic          spsr_we,
  output logic [4:0]    spsr_bank,
  output logic [31:0]   spsr_wdata
);
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011;

  logic boot_q;
  logic take, is_rst, fmask, is_ret;
  logic [4:0] tmode, voff;

  wire irq_ok = req_irq & ~cur_psr[7];
  wire fiq_ok = req_fiq & ~cur_psr[6];
  assign is_rst = boot_q | (boundary & req_reset);

  always_comb begin
    take = 1'b1; fmask = 1'b0; tmode = M_SVC; voff = 5'h00;
    if (is_rst)                     begin fmask = 1'b1; end
    else if (boundary && req_dabt)  begin tmode = M_ABT; voff = 5'h10; end
    else if (boundary && fiq_ok)    begin tmode = M_FIQ; voff = 5'h1C; fmask = 1'b1; end
    else if (boundary && irq_ok)    begin tmode = M_IRQ; voff = 5'h18; end
    else if (boundary && req_pabt)  begin tmode = M_ABT; voff = 5'h0C; end
    else if (boundary && req_undef) begin tmode = M_UND; voff = 5'h04; end
    else if (boundary && req_swi)   begin tmode = M_SVC; voff = 5'h08; end
    else take = 1'b0;
  end

  assign is_ret = ret_strobe & ~take & (cur_psr[4:0] != M_USR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      pc_we <= 1'b0; pc_wdata <= '0; psr_we <= 1'b0; psr_wdata <= '0;
      lr_we <= 1'b0; lr_bank <= '0; lr_wdata <= '0;
      spsr_we <= 1'b0; spsr_bank <= '0; spsr_wdata <= '0;
    end else begin
      boot_q     <= 1'b0;
      pc_we      <= take | is_ret;
      psr_we     <= take | is_ret;
      lr_we      <= take & ~is_rst;
      spsr_we    <= take & ~is_rst;
      lr_bank    <= tmode;
      spsr_bank  <= tmode;
      lr_wdata   <= pc_in + AW'(4);
      spsr_wdata <= cur_psr;
      if (take) begin
        pc_wdata  <= VEC_BASE + AW'(voff);
        psr_wdata <= {cur_psr[31:8], 1'b1, fmask | cur_psr[6], 1'b0, tmode};
      end else begin
        pc_wdata  <= ret_pc;
        psr_wdata <= saved_psr;
      end
    end
  end

  assert_dabt_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && req_dabt && !req_reset && !boot_q) |=> (pc_we && pc_wdata == VEC_BASE + AW'(5'h10)));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && req_irq && cur_psr[7] && !boot_q && !ret_strobe &&
     !req_reset && !req_dabt && !req_fiq && !req_pabt && !req_undef && !req_swi) |=> !pc_we);

  assert_entry_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (psr_wdata[7] && !psr_wdata[5]));

  assert_fiq_masks_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spsr_we && psr_wdata[4:0] == M_FIQ) |-> psr_wdata[6]);

  assert_no_gap_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (pc_wdata - VEC_BASE) != AW'(5'h14));

  assert_user_ret_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !boundary && !boot_q && cur_psr[4:0] == M_USR) |=> !psr_we);

  assert_link_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> lr_wdata == $past(pc_in) + AW'(4));
endmodule

// File: tb/exc_sequencer_test.sv
`timescale 1ns/1ps
module exc_sequencer_test;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic clk = 0, rst_n = 0;
  logic boundary = 0, ret_strobe = 0;
  logic r_rst = 0, r_und = 0, r_swi = 0, r_pabt = 0, r_dabt = 0, r_irq = 0, r_fiq = 0;
  logic [31:0] pc_in = 0, cur_psr = 0, saved_psr = 0, ret_pc = 0;
  logic pc_we, psr_we, lr_we, spsr_we;
  logic [31:0] pc_wdata, psr_wdata, lr_wdata, spsr_wdata;
  logic [4:0] lr_bank, spsr_bank;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  exc_sequencer #(.AW(AW), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .req_reset(r_rst), .req_undef(r_und),
    .req_swi(r_swi), .req_pabt(r_pabt), .req_dabt(r_dabt), .req_irq(r_irq), .req_fiq(r_fiq),
    .pc_in(pc_in), .cur_psr(cur_psr), .saved_psr(saved_psr), .ret_strobe(ret_strobe),
    .ret_pc(ret_pc), .pc_we(pc_we), .pc_wdata(pc_wdata), .psr_we(psr_we),
    .psr_wdata(psr_wdata), .lr_we(lr_we), .lr_bank(lr_bank), .lr_wdata(lr_wdata),
    .spsr_we(spsr_we), .spsr_bank(spsr_bank), .spsr_wdata(spsr_wdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] entry_psr(input logic [31:0] c, input logic [4:0] m, input logic f);
    return {c[31:8], 1'b1, f | c[6], 1'b0, m};
  endfunction

  // r = {reset, dabt, fiq, irq, pabt, undef, swi}; drives for one edge, then clears
  task automatic fire(input logic [6:0] r, input logic bnd, input logic ret);
    @(negedge clk);
    {r_rst, r_dabt, r_fiq, r_irq, r_pabt, r_und, r_swi} = r;
    boundary = bnd; ret_strobe = ret;
    @(negedge clk);
    {r_rst, r_dabt, r_fiq, r_irq, r_pabt, r_und, r_swi} = '0;
    boundary = 0; ret_strobe = 0;
  endtask

  task automatic t_reset;
    cur_psr = 32'h5000_0010;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pc_we", pc_we, 1);
    chk("R1 vector", pc_wdata, BASE);
    chk("R1 psr", psr_wdata, 32'h5000_00D3);
    chk("R1 no lr", lr_we, 0);
    chk("R1 no spsr", spsr_we, 0);
    @(negedge clk);
    chk("R2 pulse ends", pc_we, 0);
  endtask

  task automatic t_boundary;
    cur_psr = 32'h0000_0010;
    fire(7'b0000010, 0, 0);
    chk("R2 no boundary", pc_we, 0);
    @(negedge clk);
    chk("R2 still idle", psr_we, 0);
  endtask

  task automatic t_vectors;
    logic [6:0] rv [6] = '{7'b0000001, 7'b0000010, 7'b0000100, 7'b0001000, 7'b0010000, 7'b0100000};
    logic [4:0] mv [6] = '{5'b10011, 5'b11011, 5'b10111, 5'b10010, 5'b10001, 5'b10111};
    logic [4:0] ov [6] = '{5'h08, 5'h04, 5'h0C, 5'h18, 5'h1C, 5'h10};
    for (int i = 0; i < 6; i++) begin
      cur_psr = 32'hA000_0030;
      pc_in = 32'h0000_8000 + 32'(i * 16);
      fire(rv[i], 1, 0);
      chk("R3 vector", pc_wdata, BASE + 32'(ov[i]));
      chk("R10 gap unused", 32'(pc_wdata - BASE == 32'h14), 0);
      chk("R3 lr bank", 32'(lr_bank), 32'(mv[i]));
      chk("R5 lr data", lr_wdata, pc_in + 4);
      chk("R5 spsr", spsr_wdata, 32'hA000_0030);
      chk("R5 spsr bank", 32'(spsr_bank), 32'(mv[i]));
      chk("R6 psr", psr_wdata, entry_psr(32'hA000_0030, mv[i], i == 4));
      chk("R5 writes", {spsr_we, lr_we, psr_we, pc_we}, 4'hF);
    end
  endtask

  task automatic t_priority;
    cur_psr = 32'h0000_0010;
    fire(7'b1111111, 1, 0); chk("R4 reset wins", pc_wdata, BASE);
    fire(7'b0111111, 1, 0); chk("R4 dabt wins", pc_wdata, BASE + 32'h10);
    fire(7'b0011110, 1, 0); chk("R4 fiq wins", pc_wdata, BASE + 32'h1C);
    fire(7'b0001110, 1, 0); chk("R4 irq wins", pc_wdata, BASE + 32'h18);
    fire(7'b0000111, 1, 0); chk("R4 pabt wins", pc_wdata, BASE + 32'h0C);
    fire(7'b0000011, 1, 0); chk("R4 undef over swi", pc_wdata, BASE + 32'h04);
  endtask

  task automatic t_mask;
    cur_psr = 32'h0000_0090;
    fire(7'b0001000, 1, 0); chk("R7 irq masked", pc_we, 0);
    cur_psr = 32'h0000_0050;
    fire(7'b0011000, 1, 0); chk("R7 fiq masked, irq taken", pc_wdata, BASE + 32'h18);
    chk("R6 fiq bit kept", psr_wdata, 32'h0000_00D2);
    fire(7'b0010000, 1, 0); chk("R7 fiq alone masked", pc_we, 0);
  endtask

  task automatic t_return;
    cur_psr = 32'h0000_0092; saved_psr = 32'h2000_0030; ret_pc = 32'h0000_4444;
    fire(7'b0000000, 0, 1);
    chk("R8 psr_we", psr_we, 1);
    chk("R8 psr restore", psr_wdata, 32'h2000_0030);
    chk("R8 pc", pc_wdata, 32'h0000_4444);
    chk("R8 no lr", {lr_we, spsr_we}, 0);
    fire(7'b0000010, 1, 1);
    chk("R8 exception wins", pc_wdata, BASE + 32'h04);
  endtask

  task automatic t_user_ret;
    cur_psr = 32'h0000_0010;
    fire(7'b0000000, 0, 1);
    chk("R9 user return ignored", {psr_we, pc_we}, 0);
  endtask

  initial begin
    t_reset();
    t_boundary();
    t_vectors();
    t_priority();
    t_mask();
    t_return();
    t_user_ret();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule